// File: doc/BRIEF.md
# Dual-Issue In-Order Superscalar Scheduler

This block is the issue and completion controller of a small two-wide superscalar core. It takes up to two decoded instruction descriptors per cycle (unit class, destination register, two source registers), holds them in a two-entry decode window and hands them out strictly in program order. There are three functional units: an integer adder, an integer multiplier and a floating-point adder. Results come back through a small completion buffer that retires up to two instructions per cycle, again strictly in program order.

The block never computes data. Its job is timing. It stalls issue when a unit is already claimed and when a source register still waits on an older, unretired writer. A scoreboard records which instruction owns each pending destination, so a register with two writers in flight stays pending until the younger one retires. Outputs are per-cycle strobes carrying instruction tags: issue, per-unit execute and retire. Tags start at zero after reset and grow by one per accepted instruction in program order.

Timing: an instruction issued in cycle t executes in cycle t+1 (integer units) or in cycles t+1 and t+2 (floating-point adder). It retires no earlier than cycle t+2 or t+3 respectively, and never before every older instruction has retired.

Top module: `dual_issue_sched`

## Requirements
- R1: `fetch_ready` is high exactly when every valid window entry issues in the current cycle (or the window is empty). A pair offered while it is low is not taken. Lane 1 is taken only together with lane 0.
- R2: Accepted instructions receive tags 0, 1, 2, ... after reset, lane 0 before lane 1, wrapping modulo 2^TAG_W.
- R3: Unit codes are 0 = integer add, 1 = integer multiply, 2 = floating-point add (3 behaves as integer add). Two independent window entries for different units issue in the same cycle. An integer instruction issued in cycle t shows its execute strobe in cycle t+1 and retires in cycle t+2 if nothing older is pending.
- R4: If both window entries need the same unit, the younger issues no earlier than the next cycle.
- R5: A floating-point add shows its execute strobe with an unchanged tag for two consecutive cycles. Another floating-point add issues no earlier than two cycles after the previous one.
- R6: An instruction whose source equals the destination of an older unretired instruction waits. It issues in the same cycle the producer retires, so a multiply issued in t lets a dependent add issue in t+2.
- R7: Retirement is in program order, at most two per cycle. A retire on lane 1 carries the lane 0 tag plus one. A fast instruction behind a slow one retires no earlier than the slow one.
- R8: Issue is in program order. Lane 1 issues only together with lane 0, carrying its tag plus one, and the younger entry stalls whenever the older one does.
- R9: When two in-flight instructions write the same register, a reader waits for the younger writer to retire. The older writer's retirement does not release it.
- R10: After reset, no issue, execute or retire strobe is active and `fetch_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 2 | Lane valid; lane 0 is older |
| fetch_unit | input | 2x2 | Unit class per lane |
| fetch_dst | input | 2x5 | Destination register per lane |
| fetch_srca | input | 2x5 | First source register per lane |
| fetch_srcb | input | 2x5 | Second source register per lane |
| fetch_ready | output | 1 | Offered pair is accepted at this edge |
| issue_valid | output | 2 | Issue strobe per window slot |
| issue_tag | output | 2xTAG_W | Tag of each issuing instruction |
| ex_valid | output | 3 | Execute strobe: [0] int add, [1] int mul, [2] fp add |
| ex_tag | output | 3xTAG_W | Tag executing in each unit |
| retire_valid | output | 2 | Retire strobe per lane |
| retire_tag | output | 2xTAG_W | Tag of each retiring instruction |

## Verification
Two functions can fall in the same cycle: the retirement of a producer and the issue of the instruction waiting on its result. The scoreboard must release the register in that cycle, but only when the retiring tag is the register's current owner. Directed programs provoke this with a multiply followed by a dependent add, and with two writers of one register where the younger is the slow floating-point add. The bench records the cycle in which each tag issues and retires and compares them with cycles worked out by hand from the timing rules. A six-instruction mixed program also brings unit conflicts, a two-cycle floating-point add and a two-wide retire into overlapping cycles.

// File: rtl/sched_pkg.sv
package sched_pkg;
    localparam int REG_W = 5;
    localparam int NREG = 1 << REG_W;
    localparam int NUNIT = 3;
    localparam int FADD_IDX = 2;

    typedef enum logic [1:0] {
        U_IADD = 2'd0,
        U_IMUL = 2'd1,
        U_FADD = 2'd2
    } unit_e;

    typedef struct packed {
        unit_e            unit;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] srca;
        logic [REG_W-1:0] srcb;
    } instr_t;

    function automatic unit_e norm_unit(input logic [1:0] code);
        case (code)
            2'd1:    return U_IMUL;
            2'd2:    return U_FADD;
            default: return U_IADD;
        endcase
    endfunction

    function automatic logic reads_reg(input instr_t ins, input logic [REG_W-1:0] r);
        return (ins.srca == r) || (ins.srcb == r);
    endfunction
endpackage

// File: rtl/sched_scoreboard.sv
module sched_scoreboard import sched_pkg::*; #(
    parameter int TAG_W = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [1:0]                 set_v,
    input  logic [1:0][REG_W-1:0]      set_reg,
    input  logic [1:0][TAG_W-1:0]      set_tag,
    input  logic [1:0]                 clr_v,
    input  logic [1:0][REG_W-1:0]      clr_reg,
    input  logic [1:0][TAG_W-1:0]      clr_tag,
    input  logic [3:0][REG_W-1:0]      q_reg,
    output logic [3:0]                 q_busy
);
    logic [NREG-1:0]  pend;
    logic [TAG_W-1:0] owner [NREG];

    function automatic logic released(input logic [REG_W-1:0] r,
                                      input logic [1:0] cv,
                                      input logic [1:0][REG_W-1:0] cr,
                                      input logic [1:0][TAG_W-1:0] ct,
                                      input logic [TAG_W-1:0] own);
        return (cv[0] && cr[0] == r && ct[0] == own) ||
               (cv[1] && cr[1] == r && ct[1] == own);
    endfunction

    always_comb begin
        for (int q = 0; q < 4; q++) begin
            q_busy[q] = pend[q_reg[q]] &&
                        !released(q_reg[q], clr_v, clr_reg, clr_tag, owner[q_reg[q]]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            for (int r = 0; r < NREG; r++) owner[r] <= '0;
        end else begin
            for (int r = 0; r < NREG; r++) begin
                if (released(REG_W'(r), clr_v, clr_reg, clr_tag, owner[r])) pend[r] <= 1'b0;
                for (int k = 0; k < 2; k++) begin
                    if (set_v[k] && set_reg[k] == REG_W'(r)) begin
                        pend[r]  <= 1'b1;
                        owner[r] <= set_tag[k];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/sched_units.sv
module sched_units import sched_pkg::*; #(
    parameter int TAG_W = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUNIT-1:0]            go,
    input  logic [NUNIT-1:0][TAG_W-1:0] go_tag,
    output logic [NUNIT-1:0]            ex_valid,
    output logic [NUNIT-1:0][TAG_W-1:0] ex_tag,
    output logic [NUNIT-1:0]            fin_valid,
    output logic                        fp_free
);
    localparam int NINT = NUNIT - 1;

    for (genvar u = 0; u < NINT; u++) begin : g_int
        logic             v_q;
        logic [TAG_W-1:0] t_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
                t_q <= '0;
            end else begin
                v_q <= go[u];
                if (go[u]) t_q <= go_tag[u];
            end
        end
        assign ex_valid[u]  = v_q;
        assign ex_tag[u]    = t_q;
        assign fin_valid[u] = v_q;
    end

    logic [1:0]       fp_left;
    logic [TAG_W-1:0] fp_tag;

    always_ff @(posedge clk) begin
        if (rst) begin
            fp_left <= 2'd0;
            fp_tag  <= '0;
        end else if (go[FADD_IDX]) begin
            fp_left <= 2'd2;
            fp_tag  <= go_tag[FADD_IDX];
        end else if (fp_left != 2'd0) begin
            fp_left <= fp_left - 2'd1;
        end
    end

    assign ex_valid[FADD_IDX]  = (fp_left != 2'd0);
    assign ex_tag[FADD_IDX]    = fp_tag;
    assign fin_valid[FADD_IDX] = (fp_left == 2'd1);
    assign fp_free             = (fp_left <= 2'd1);
endmodule

// File: rtl/sched_rob.sv
module sched_rob import sched_pkg::*; #(
    parameter int TAG_W = 4,
    parameter int IDX_W = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [1:0]                  alloc_v,
    input  logic [1:0][TAG_W-1:0]       alloc_tag,
    input  logic [1:0][REG_W-1:0]       alloc_dst,
    input  logic [NUNIT-1:0]            fin_v,
    input  logic [NUNIT-1:0][TAG_W-1:0] fin_tag,
    output logic [1:0]                  ret_v,
    output logic [1:0][TAG_W-1:0]       ret_tag,
    output logic [1:0][REG_W-1:0]       ret_dst,
    output logic [IDX_W:0]              occ
);
    localparam int DEPTH = 1 << IDX_W;
    localparam logic [TAG_W-1:0] TAG_ONE = TAG_W'(1);
    localparam logic [IDX_W:0]   OCC_ONE = (IDX_W+1)'(1);

    logic [DEPTH-1:0] done;
    logic [REG_W-1:0] dst_q [DEPTH];
    logic [TAG_W-1:0] head;
    logic [TAG_W-1:0] head_n;
    logic [IDX_W:0]   nalloc, nret;

    assign head_n     = head + TAG_ONE;
    assign ret_v[0]   = (occ != '0) && done[head[IDX_W-1:0]];
    assign ret_v[1]   = ret_v[0] && (occ > OCC_ONE) && done[head_n[IDX_W-1:0]];
    assign ret_tag[0] = head;
    assign ret_tag[1] = head_n;
    assign ret_dst[0] = dst_q[head[IDX_W-1:0]];
    assign ret_dst[1] = dst_q[head_n[IDX_W-1:0]];
    assign nalloc     = (IDX_W+1)'(alloc_v[0]) + (IDX_W+1)'(alloc_v[1]);
    assign nret       = (IDX_W+1)'(ret_v[0]) + (IDX_W+1)'(ret_v[1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            done <= '0;
            head <= '0;
            occ  <= '0;
        end else begin
            for (int k = 0; k < NUNIT; k++)
                if (fin_v[k]) done[fin_tag[k][IDX_W-1:0]] <= 1'b1;
            for (int k = 0; k < 2; k++)
                if (alloc_v[k]) done[alloc_tag[k][IDX_W-1:0]] <= 1'b0;
            head <= head + TAG_W'(nret);
            occ  <= occ + nalloc - nret;
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < 2; k++)
            if (alloc_v[k]) dst_q[alloc_tag[k][IDX_W-1:0]] <= alloc_dst[k];
    end
endmodule

// File: rtl/dual_issue_sched.sv
module dual_issue_sched import sched_pkg::*; #(
    parameter int TAG_W     = 4,
    parameter int ROB_IDX_W = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [1:0]                  fetch_valid,
    input  logic [1:0][1:0]             fetch_unit,
    input  logic [1:0][REG_W-1:0]       fetch_dst,
    input  logic [1:0][REG_W-1:0]       fetch_srca,
    input  logic [1:0][REG_W-1:0]       fetch_srcb,
    output logic                        fetch_ready,
    output logic [1:0]                  issue_valid,
    output logic [1:0][TAG_W-1:0]       issue_tag,
    output logic [NUNIT-1:0]            ex_valid,
    output logic [NUNIT-1:0][TAG_W-1:0] ex_tag,
    output logic [1:0]                  retire_valid,
    output logic [1:0][TAG_W-1:0]       retire_tag
);
    localparam logic [TAG_W-1:0]     TAG_ONE  = TAG_W'(1);
    localparam logic [ROB_IDX_W:0]   OCC_ONE  = (ROB_IDX_W+1)'(1);
    localparam logic [ROB_IDX_W:0]   ROB_FULL = (ROB_IDX_W+1)'(1 << ROB_IDX_W);

    instr_t            win [2];
    logic [1:0]        wv;
    logic [TAG_W-1:0]  wtag, wtag1, next_tag;
    logic              iss0, iss1, free0, free1, fp_free, take;
    logic [3:0]        busy;
    logic [ROB_IDX_W:0] occ;
    logic [1:0][REG_W-1:0] ret_dst;
    logic [NUNIT-1:0]  go, fin_v;
    logic [NUNIT-1:0][TAG_W-1:0] go_tag;

    assign wtag1 = wtag + TAG_ONE;
    assign free0 = (win[0].unit != U_FADD) || fp_free;
    assign free1 = (win[1].unit != U_FADD) || fp_free;
    assign iss0  = wv[0] && free0 && !busy[0] && !busy[1] && (occ != ROB_FULL);
    assign iss1  = iss0 && wv[1] && free1 && (win[1].unit != win[0].unit) &&
                   !busy[2] && !busy[3] && !reads_reg(win[1], win[0].dst) &&
                   ((occ + OCC_ONE) < ROB_FULL);
    assign fetch_ready = (!wv[0] || iss0) && (!wv[1] || iss1);
    assign take        = fetch_ready && fetch_valid[0];

    assign issue_valid  = {iss1, iss0};
    assign issue_tag[0] = wtag;
    assign issue_tag[1] = wtag1;

    always_ff @(posedge clk) begin
        if (rst) begin
            wv       <= 2'b00;
            wtag     <= '0;
            next_tag <= '0;
        end else if (take) begin
            for (int k = 0; k < 2; k++)
                win[k] <= '{unit: norm_unit(fetch_unit[k]), dst: fetch_dst[k],
                            srca: fetch_srca[k], srcb: fetch_srcb[k]};
            wv       <= {fetch_valid[1], 1'b1};
            wtag     <= next_tag;
            next_tag <= next_tag + (fetch_valid[1] ? TAG_W'(2) : TAG_ONE);
        end else if (fetch_ready) begin
            wv <= 2'b00;
        end else if (iss0) begin
            win[0] <= win[1];
            wv     <= 2'b01;
            wtag   <= wtag1;
        end
    end

    for (genvar u = 0; u < NUNIT; u++) begin : g_route
        logic sel0, sel1;
        assign sel0      = iss0 && (win[0].unit == unit_e'(u));
        assign sel1      = iss1 && (win[1].unit == unit_e'(u));
        assign go[u]     = sel0 || sel1;
        assign go_tag[u] = sel0 ? wtag : wtag1;
    end

    sched_scoreboard #(.TAG_W(TAG_W)) u_sb (
        .clk(clk), .rst(rst),
        .set_v({iss1, iss0}), .set_reg({win[1].dst, win[0].dst}), .set_tag({wtag1, wtag}),
        .clr_v(retire_valid), .clr_reg(ret_dst), .clr_tag(retire_tag),
        .q_reg({win[1].srcb, win[1].srca, win[0].srcb, win[0].srca}),
        .q_busy(busy)
    );

    sched_units #(.TAG_W(TAG_W)) u_units (
        .clk(clk), .rst(rst), .go(go), .go_tag(go_tag),
        .ex_valid(ex_valid), .ex_tag(ex_tag), .fin_valid(fin_v), .fp_free(fp_free)
    );

    sched_rob #(.TAG_W(TAG_W), .IDX_W(ROB_IDX_W)) u_rob (
        .clk(clk), .rst(rst),
        .alloc_v({iss1, iss0}), .alloc_tag({wtag1, wtag}), .alloc_dst({win[1].dst, win[0].dst}),
        .fin_v(fin_v), .fin_tag(ex_tag),
        .ret_v(retire_valid), .ret_tag(retire_tag), .ret_dst(ret_dst), .occ(occ)
    );
endmodule

// File: rtl/sched_checker.sv
module sched_checker #(
    parameter int TAG_W = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  fetch_ready,
    input logic [1:0]            issue_valid,
    input logic [1:0][TAG_W-1:0] issue_tag,
    input logic [2:0]            ex_valid,
    input logic [2:0][TAG_W-1:0] ex_tag,
    input logic [1:0]            retire_valid,
    input logic [1:0][TAG_W-1:0] retire_tag
);
    localparam logic [TAG_W-1:0] TAG_ONE = TAG_W'(1);

    AST_ISSUE_ORDER: assert property (@(posedge clk) disable iff (rst)
        issue_valid[1] |-> issue_valid[0] && issue_tag[1] == issue_tag[0] + TAG_ONE); // R8

    AST_RETIRE_ORDER: assert property (@(posedge clk) disable iff (rst)
        retire_valid[1] |-> retire_valid[0] && retire_tag[1] == retire_tag[0] + TAG_ONE); // R7

    AST_FP_TWO_CYCLES: assert property (@(posedge clk) disable iff (rst)
        ex_valid[2] && (!$past(ex_valid[2]) || ex_tag[2] != $past(ex_tag[2]))
        |=> ex_valid[2] && $stable(ex_tag[2])); // R5

    AST_IADD_AFTER_ISSUE: assert property (@(posedge clk) disable iff (rst)
        ex_valid[0] |-> $past(issue_valid[0])); // R3

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> fetch_ready && issue_valid == 2'b00 && retire_valid == 2'b00 && ex_valid == 3'b000); // R10
endmodule

bind dual_issue_sched sched_checker #(.TAG_W(TAG_W)) u_chk (
    .clk(clk), .rst(rst), .fetch_ready(fetch_ready),
    .issue_valid(issue_valid), .issue_tag(issue_tag),
    .ex_valid(ex_valid), .ex_tag(ex_tag),
    .retire_valid(retire_valid), .retire_tag(retire_tag)
);

// File: tb/dual_issue_sched_tb.sv
`timescale 1ns/1ps
module dual_issue_sched_tb;
    localparam int TW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0]          fetch_valid = '0;
    logic [1:0][1:0]     fetch_unit = '0;
    logic [1:0][4:0]     fetch_dst = '0, fetch_srca = '0, fetch_srcb = '0;
    logic                fetch_ready;
    logic [1:0]          issue_valid;
    logic [1:0][TW-1:0]  issue_tag;
    logic [2:0]          ex_valid;
    logic [2:0][TW-1:0]  ex_tag;
    logic [1:0]          retire_valid;
    logic [1:0][TW-1:0]  retire_tag;

    always #2 clk = ~clk;

    dual_issue_sched #(.TAG_W(TW), .ROB_IDX_W(3)) u_dut (
        .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_unit(fetch_unit),
        .fetch_dst(fetch_dst), .fetch_srca(fetch_srca), .fetch_srcb(fetch_srcb),
        .fetch_ready(fetch_ready), .issue_valid(issue_valid), .issue_tag(issue_tag),
        .ex_valid(ex_valid), .ex_tag(ex_tag),
        .retire_valid(retire_valid), .retire_tag(retire_tag)
    );

    int n_chk = 0, n_fail = 0;
    bit done_flag = 0;
    int p_unit [16], p_dst [16], p_a [16], p_b [16];
    int n_prog;
    int iss_c [16], ret_c [16], ex_first [16], ex_n [16], rdy_c [32];

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic put(input int i, input int u, input int d, input int a, input int b);
        p_unit[i] = u; p_dst[i] = d; p_a[i] = a; p_b[i] = b;
        if (i + 1 > n_prog) n_prog = i + 1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        fetch_valid = '0;
        n_prog = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run(input int ncyc);
        int ptr = 0;
        for (int t = 0; t < 16; t++) begin
            iss_c[t] = -1; ret_c[t] = -1; ex_first[t] = -1; ex_n[t] = 0;
        end
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            fetch_valid = '0;
            for (int k = 0; k < 2; k++) begin
                if (ptr + k < n_prog) begin
                    fetch_valid[k] = 1'b1;
                    fetch_unit[k]  = 2'(p_unit[ptr+k]);
                    fetch_dst[k]   = 5'(p_dst[ptr+k]);
                    fetch_srca[k]  = 5'(p_a[ptr+k]);
                    fetch_srcb[k]  = 5'(p_b[ptr+k]);
                end
            end
            #1;
            rdy_c[c] = fetch_ready;
            for (int k = 0; k < 2; k++) begin
                if (issue_valid[k])  iss_c[issue_tag[k]] = c;
                if (retire_valid[k]) ret_c[retire_tag[k]] = c;
            end
            for (int u = 0; u < 3; u++) begin
                if (ex_valid[u]) begin
                    if (ex_first[ex_tag[u]] < 0) ex_first[ex_tag[u]] = c;
                    ex_n[ex_tag[u]]++;
                end
            end
            if (fetch_ready && fetch_valid[0]) ptr += fetch_valid[1] ? 2 : 1;
        end
        fetch_valid = '0;
    endtask

    // R10: idle outputs after reset
    task automatic t_reset();
        do_reset();
        #1;
        check("R10", "fetch_ready", fetch_ready, 1);
        check("R10", "issue_valid", issue_valid, 0);
        check("R10", "ex_valid", ex_valid, 0);
        check("R10", "retire_valid", retire_valid, 0);
    endtask

    // R3, R2: independent multiply and add issue together
    task automatic t_pair();
        do_reset();
        put(0, 1, 4, 3, 1);
        put(1, 0, 2, 6, 5);
        run(8);
        check("R2", "tag0 issue", iss_c[0], 1);
        check("R3", "tag1 issue", iss_c[1], 1);
        check("R3", "tag1 execute", ex_first[1], 2);
        check("R3", "tag0 retire", ret_c[0], 3);
        check("R3", "tag1 retire", ret_c[1], 3);
    endtask

    // R4, R1: same-unit pair splits, fetch held
    task automatic t_conflict();
        do_reset();
        put(0, 0, 1, 2, 3);
        put(1, 0, 4, 5, 6);
        put(2, 1, 7, 8, 9);
        run(10);
        check("R4", "tag1 issue", iss_c[1], 2);
        check("R4", "tag1 retire", ret_c[1], 4);
        check("R1", "ready while split", rdy_c[1], 0);
        check("R1", "ready after drain", rdy_c[2], 1);
        check("R1", "tag2 issue", iss_c[2], 3);
    endtask

    // R6: dependent add issues in producer's retire cycle
    task automatic t_raw();
        do_reset();
        put(0, 1, 4, 3, 1);
        put(1, 0, 2, 4, 5);
        run(10);
        check("R6", "producer issue", iss_c[0], 1);
        check("R6", "consumer issue", iss_c[1], 3);
        check("R6", "consumer retire", ret_c[1], 5);
    endtask

    // R7: fast add waits behind slow fp add
    task automatic t_order();
        do_reset();
        put(0, 2, 12, 13, 14);
        put(1, 0, 1, 8, 9);
        run(10);
        check("R7", "add issue", iss_c[1], 1);
        check("R7", "fp retire", ret_c[0], 4);
        check("R7", "add retire", ret_c[1], 4);
        check("R5", "fp execute cycles", ex_n[0], 2);
    endtask

    // R5: back-to-back fp adds
    task automatic t_fp();
        do_reset();
        put(0, 2, 1, 2, 3);
        put(1, 2, 4, 5, 6);
        run(12);
        check("R5", "second fp issue", iss_c[1], 3);
        check("R5", "second fp execute", ex_first[1], 4);
        check("R5", "second fp execute cycles", ex_n[1], 2);
        check("R5", "second fp retire", ret_c[1], 6);
    endtask

    // R8, R7: mixed six-instruction program
    task automatic t_mixed();
        int ei [6] = '{1, 1, 2, 3, 5, 6};
        int er [6] = '{4, 4, 5, 5, 7, 8};
        do_reset();
        put(0, 2, 12, 13, 14);
        put(1, 0, 1, 8, 9);
        put(2, 1, 4, 2, 3);
        put(3, 1, 5, 6, 7);
        put(4, 0, 10, 5, 7);
        put(5, 0, 11, 2, 3);
        run(14);
        for (int i = 0; i < 6; i++) begin
            check("R8", $sformatf("tag%0d issue", i), iss_c[i], ei[i]);
            check("R7", $sformatf("tag%0d retire", i), ret_c[i], er[i]);
        end
    endtask

    // R9: reader waits for younger of two writers
    task automatic t_waw();
        do_reset();
        put(0, 0, 4, 1, 2);
        put(1, 2, 4, 3, 5);
        put(2, 0, 6, 4, 7);
        run(10);
        check("R9", "older writer retire", ret_c[0], 3);
        check("R9", "reader issue", iss_c[2], 4);
        check("R9", "reader retire", ret_c[2], 6);
    endtask

    task automatic finish_up();
        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_pair();
        t_conflict();
        t_raw();
        t_order();
        t_fp();
        t_mixed();
        t_waw();
        finish_up();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end
endmodule